// File: doc/BRIEF.md
# Keyboard Controller Gate Trap

This block sits beside the host I/O decoder and watches every cycle aimed at the two legacy keyboard-controller ports, the data port (60h) and the command/status port (64h). For each such cycle it decides, in the same clock, whether the cycle goes on to the keyboard controller (forward) or is held back (trap). It also decides whether to raise a one-clock system-management interrupt request. Beside the per-cycle trap enables, it follows the address-gate command sequence. That sequence is an open command D1h on port 64h, then a data byte on port 60h, then a close command FFh on port 64h. Cycles inside the sequence are forced through, and a separate enable can request an interrupt when the sequence ends.

The controller has three states. `ST_IDLE` means no sequence is open. `ST_ARMED` means the open command has been seen. `ST_DATA_SEEN` means the data byte followed the open command. The transitions are as follows. An open command moves `ST_IDLE` to `ST_ARMED`. A data write moves `ST_ARMED` to `ST_DATA_SEEN`. A repeated open command keeps the block in `ST_ARMED`, and so does a status read. Any other command write or a data read moves `ST_ARMED` back to `ST_IDLE`. Every cycle in `ST_DATA_SEEN` returns the block to `ST_IDLE`. A clear pending output is high whenever the block is outside `ST_IDLE`. The configuration byte `cfg` works as follows:

- Bit 0 traps data-port reads.
- Bit 1 traps data-port writes.
- Bit 2 traps command-port reads.
- Bit 3 traps command-port writes.
- Bit 7 requests an interrupt when a sequence ends.
- Bits 4 to 6 are unused.

Top module: `kbc_gate_trap`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the block in `ST_IDLE`, with `pend_o` low after that edge, and this holds also when the reset comes in the middle of a sequence.
- R2: In `ST_IDLE`, a write of D1h to port 64h forwards the cycle (`fwd_o`=1, `smi_o`=0) whatever `cfg` holds. After that edge, `pend_o` is 1 (`ST_ARMED`).
- R3: In `ST_IDLE`, every other target cycle leaves the block in `ST_IDLE`. Its trap bit is chosen by cycle type: cfg[3] for a port-64h write, cfg[2] for a port-64h read, cfg[1] for a port-60h write and cfg[0] for a port-60h read. A set bit gives `fwd_o`=0 and `smi_o`=1. A clear bit gives `fwd_o`=1 and `smi_o`=0.
- R4: In `ST_ARMED`, any write to port 60h is forwarded with no interrupt, even when cfg[1] is set, and moves the block to `ST_DATA_SEEN`. `pend_o` stays 1.
- R5: In `ST_ARMED`, a further write of D1h to port 64h is forwarded with no interrupt, even when cfg[3] is set, and the block stays in `ST_ARMED`.
- R6: In `ST_ARMED`, a port-64h write other than D1h returns to `ST_IDLE` and clears `pend_o`. It is trapped per cfg[3], and `smi_o` is cfg[3] OR cfg[7].
- R7: In `ST_ARMED`, a port-60h read returns to `ST_IDLE` and clears `pend_o`. It is trapped per cfg[0], and `smi_o` is cfg[0] OR cfg[7].
- R8: In `ST_ARMED`, a port-64h read keeps the block in `ST_ARMED` with `pend_o` at 1. It is trapped, with an interrupt, only when cfg[2] is set.
- R9: In `ST_DATA_SEEN`, a write of FFh to port 64h is always forwarded and returns to `ST_IDLE` with `pend_o` cleared. `smi_o` equals cfg[7].
- R10: In `ST_DATA_SEEN`, every other target cycle returns to `ST_IDLE` and clears `pend_o`. It is trapped per the R3 bit for its type, and `smi_o` is that bit OR cfg[7].
- R11: A clock with `cyc_vld` low, or with an address other than 60h or 64h, gives `fwd_o`=0 and `smi_o`=0 and leaves the state and `pend_o` unchanged. Bits 4 to 6 of `cfg` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_vld | input | 1 | One I/O cycle is presented in this clock |
| cyc_addr | input | ADDR_W (16) | I/O port address of the cycle |
| cyc_wr | input | 1 | 1 = write, 0 = read |
| cyc_wdata | input | 8 | Write data byte |
| cfg | input | 8 | Trap enables [3:0], end-of-sequence interrupt enable [7] |
| fwd_o | output | 1 | Cycle goes on to the keyboard controller |
| smi_o | output | 1 | One-clock interrupt request |
| pend_o | output | 1 | Gate sequence open (state is not `ST_IDLE`) |

## Verification
Two functions can land in the same cycle. The end-of-sequence interrupt from cfg[7] can coincide with forwarding the close command, giving `fwd_o` and `smi_o` together. It can also coincide with the per-cycle trap interrupt on an improper end, which must yield one merged pulse and a blocked cycle. The bench provokes both by sweeping every three-cycle ordering of the six target cycle types under every combination of cfg bits 0 to 3 and 7. It judges each cycle against a table built from the requirements, with the expected state carried from one cycle to the next. Idle clocks and off-target addresses are mixed into the armed state, and a reset is issued mid-sequence.

// File: rtl/kbc_trap_pkg.sv
package kbc_trap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ARMED     = 2'd1,
        ST_DATA_SEEN = 2'd2
    } gate_st_e;

    typedef enum logic [2:0] {
        CK_NONE      = 3'd0,
        CK_CMD_OPEN  = 3'd1,
        CK_CMD_CLOSE = 3'd2,
        CK_CMD_OTHER = 3'd3,
        CK_CMD_RD    = 3'd4,
        CK_DATA_WR   = 3'd5,
        CK_DATA_RD   = 3'd6
    } cyc_kind_e;

    localparam int CFG_W      = 8;
    localparam int TB_DATA_RD = 0;
    localparam int TB_DATA_WR = 1;
    localparam int TB_CMD_RD  = 2;
    localparam int TB_CMD_WR  = 3;
    localparam int TB_SEQ_END = 7;

    typedef struct packed {
        gate_st_e nxt;
        logic     fwd;
        logic     smi;
    } gate_dec_t;

endpackage

// File: rtl/kbc_cycle_decode.sv
module kbc_cycle_decode
    import kbc_trap_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter logic [15:0] DATA_PORT  = 16'h0060,
    parameter logic [15:0] CMD_PORT   = 16'h0064,
    parameter logic [7:0]  OPEN_CODE  = 8'hD1,
    parameter logic [7:0]  CLOSE_CODE = 8'hFF
) (
    input  logic              cyc_vld,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_wr,
    input  logic [DATA_W-1:0] cyc_wdata,
    output cyc_kind_e         kind
);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_PORT);
    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_PORT);
    localparam logic [DATA_W-1:0] OPEN_D = DATA_W'(OPEN_CODE);
    localparam logic [DATA_W-1:0] CLOSE_D = DATA_W'(CLOSE_CODE);

    logic hit_data;
    logic hit_cmd;

    assign hit_data = cyc_vld && (cyc_addr == DATA_A);
    assign hit_cmd  = cyc_vld && (cyc_addr == CMD_A);

    always_comb begin
        kind = CK_NONE;
        if (hit_cmd) begin
            if (!cyc_wr)                  kind = CK_CMD_RD;
            else if (cyc_wdata == OPEN_D) kind = CK_CMD_OPEN;
            else if (cyc_wdata == CLOSE_D) kind = CK_CMD_CLOSE;
            else                          kind = CK_CMD_OTHER;
        end else if (hit_data) begin
            kind = cyc_wr ? CK_DATA_WR : CK_DATA_RD;
        end
    end
endmodule

// File: rtl/kbc_trap_policy.sv
module kbc_trap_policy
    import kbc_trap_pkg::*;
(
    input  gate_st_e          state,
    input  cyc_kind_e         kind,
    input  logic [CFG_W-1:0]  cfg,
    output gate_dec_t         dec
);
    logic trap_b;
    logic end_smi;

    // per-cycle trap bit selected by cycle type
    always_comb begin
        unique case (kind)
            CK_CMD_OPEN,
            CK_CMD_CLOSE,
            CK_CMD_OTHER: trap_b = cfg[TB_CMD_WR];
            CK_CMD_RD:    trap_b = cfg[TB_CMD_RD];
            CK_DATA_WR:   trap_b = cfg[TB_DATA_WR];
            CK_DATA_RD:   trap_b = cfg[TB_DATA_RD];
            default:      trap_b = 1'b0;
        endcase
    end

    assign end_smi = cfg[TB_SEQ_END];

    // output and next-state process
    always_comb begin
        dec.nxt = state;
        dec.fwd = 1'b0;
        dec.smi = 1'b0;
        if (kind != CK_NONE) begin
            dec.fwd = !trap_b;
            dec.smi = trap_b;
            unique case (state)
                ST_IDLE: begin
                    if (kind == CK_CMD_OPEN) begin
                        dec.nxt = ST_ARMED;
                        dec.fwd = 1'b1;
                        dec.smi = 1'b0;
                    end
                end
                ST_ARMED: begin
                    unique case (kind)
                        CK_DATA_WR: begin
                            dec.nxt = ST_DATA_SEEN;
                            dec.fwd = 1'b1;
                            dec.smi = 1'b0;
                        end
                        CK_CMD_OPEN: begin
                            dec.nxt = ST_ARMED;
                            dec.fwd = 1'b1;
                            dec.smi = 1'b0;
                        end
                        CK_CMD_RD: begin
                            dec.nxt = ST_ARMED;
                        end
                        default: begin
                            dec.nxt = ST_IDLE;
                            dec.smi = trap_b | end_smi;
                        end
                    endcase
                end
                ST_DATA_SEEN: begin
                    dec.nxt = ST_IDLE;
                    if (kind == CK_CMD_CLOSE) begin
                        dec.fwd = 1'b1;
                        dec.smi = end_smi;
                    end else begin
                        dec.smi = trap_b | end_smi;
                    end
                end
                default: begin
                    dec.nxt = ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/kbc_trap_state.sv
module kbc_trap_state
    import kbc_trap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    input  gate_st_e nxt,
    output gate_st_e state_q,
    output logic     pend_q
);
    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else if (adv) begin
            state_q <= nxt;
            pend_q  <= (nxt != ST_IDLE);
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE) && !pend_q); // R1

    AST_HOLD_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state_q) && $stable(pend_q)); // R11

    AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (rst)
        pend_q == (state_q != ST_IDLE)); // R2

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        state_q != gate_st_e'(2'd3)); // R1
endmodule

// File: rtl/kbc_gate_trap.sv
module kbc_gate_trap
    import kbc_trap_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] DATA_PORT  = 16'h0060,
    parameter logic [15:0] CMD_PORT   = 16'h0064,
    parameter logic [7:0]  OPEN_CODE  = 8'hD1,
    parameter logic [7:0]  CLOSE_CODE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_vld,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_wr,
    input  logic [7:0]        cyc_wdata,
    input  logic [CFG_W-1:0]  cfg,
    output logic              fwd_o,
    output logic              smi_o,
    output logic              pend_o
);
    cyc_kind_e kind;
    gate_st_e  state;
    gate_dec_t dec;
    logic      hit;

    kbc_cycle_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (8),
        .DATA_PORT  (DATA_PORT),
        .CMD_PORT   (CMD_PORT),
        .OPEN_CODE  (OPEN_CODE),
        .CLOSE_CODE (CLOSE_CODE)
    ) u_dec (
        .cyc_vld   (cyc_vld),
        .cyc_addr  (cyc_addr),
        .cyc_wr    (cyc_wr),
        .cyc_wdata (cyc_wdata),
        .kind      (kind)
    );

    kbc_trap_policy u_pol (
        .state (state),
        .kind  (kind),
        .cfg   (cfg),
        .dec   (dec)
    );

    assign hit = (kind != CK_NONE);

    kbc_trap_state u_st (
        .clk     (clk),
        .rst     (rst),
        .adv     (hit),
        .nxt     (dec.nxt),
        .state_q (state),
        .pend_q  (pend_o)
    );

    assign fwd_o = dec.fwd;
    assign smi_o = dec.smi;

    AST_QUIET_OFF_TARGET: assert property (@(posedge clk) disable iff (rst)
        !hit |-> !fwd_o && !smi_o); // R11

    AST_TRAP_RAISES_SMI: assert property (@(posedge clk) disable iff (rst)
        hit |-> fwd_o || smi_o); // R3

    AST_OPEN_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && kind == CK_CMD_OPEN) |=> pend_o); // R2

    AST_ARMED_DATA_FORCED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && kind == CK_DATA_WR) |-> fwd_o && !smi_o); // R4

    AST_ARMED_REOPEN_FORCED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && kind == CK_CMD_OPEN) |-> fwd_o && !smi_o); // R5

    AST_DATA_SEEN_EXITS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA_SEEN && hit) |=> !pend_o); // R10

    AST_CLOSE_FORWARDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA_SEEN && kind == CK_CMD_CLOSE) |-> fwd_o); // R9
endmodule

// File: tb/sim_kbc_gate_trap.sv
module sim_kbc_gate_trap;
    logic        clk = 1'b0;
    logic        rst;
    logic        cyc_vld;
    logic [15:0] cyc_addr;
    logic        cyc_wr;
    logic [7:0]  cyc_wdata;
    logic [7:0]  cfg;
    logic        fwd_o, smi_o, pend_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;
    int mst   = 0; // expected state: 0 idle, 1 armed, 2 data seen

    always #4 clk = ~clk; // 125 MHz

    kbc_gate_trap u0 (
        .clk(clk), .rst(rst), .cyc_vld(cyc_vld), .cyc_addr(cyc_addr),
        .cyc_wr(cyc_wr), .cyc_wdata(cyc_wdata), .cfg(cfg),
        .fwd_o(fwd_o), .smi_o(smi_o), .pend_o(pend_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s cfg=%02h st=%0d actual=%0b expected=%0b",
                     req, what, cfg, mst, act, exp);
        end
    endtask

    // kinds: 0 wr64 D1, 1 wr64 FF, 2 wr64 55, 3 rd64, 4 wr60, 5 rd60
    function automatic logic trap_bit(input int k, input logic [7:0] c);
        case (k)
            0, 1, 2: return c[3];
            3:       return c[2];
            4:       return c[1];
            default: return c[0];
        endcase
    endfunction

    function automatic string req_of(input int st, input int k);
        if (st == 0) return (k == 0) ? "R2" : "R3";
        if (st == 1) begin
            case (k)
                4:       return "R4";
                0:       return "R5";
                1, 2:    return "R6";
                5:       return "R7";
                default: return "R8";
            endcase
        end
        return (k == 1) ? "R9" : "R10";
    endfunction

    task automatic model(input int st, input int k, input logic [7:0] c,
                         output int nst, output logic f, output logic s);
        logic b;
        b = trap_bit(k, c);
        nst = 0; f = !b; s = b;
        if (st == 0) begin
            if (k == 0) begin nst = 1; f = 1'b1; s = 1'b0; end
        end else if (st == 1) begin
            if (k == 4)      begin nst = 2; f = 1'b1; s = 1'b0; end
            else if (k == 0) begin nst = 1; f = 1'b1; s = 1'b0; end
            else if (k == 3) begin nst = 1; end
            else             begin nst = 0; s = b | c[7]; end
        end else begin
            nst = 0;
            if (k == 1) begin f = 1'b1; s = c[7]; end
            else        s = b | c[7];
        end
    endtask

    task automatic do_cycle(input int k);
        int nst;
        logic ef, es;
        string rq;
        @(negedge clk);
        cyc_vld  = 1'b1;
        cyc_addr = (k >= 4) ? 16'h0060 : 16'h0064;
        cyc_wr   = (k == 0 || k == 1 || k == 2 || k == 4);
        cyc_wdata = (k == 0) ? 8'hD1 : (k == 1) ? 8'hFF : (k == 4) ? 8'hA5 : 8'h55;
        #2;
        model(mst, k, cfg, nst, ef, es);
        rq = req_of(mst, k);
        chk(rq, "fwd", fwd_o, ef);
        chk(rq, "smi", smi_o, es);
        @(posedge clk);
        #1;
        mst = nst;
        chk(rq, "pend", pend_o, (mst != 0));
        cyc_vld = 1'b0;
    endtask

    // idle clock or off-target address: nothing fires, state held (R11)
    task automatic quiet_cycle(input bit off_addr);
        @(negedge clk);
        cyc_vld   = off_addr;
        cyc_addr  = off_addr ? 16'h0065 : 16'h0064;
        cyc_wr    = 1'b1;
        cyc_wdata = 8'h12;
        #2;
        chk("R11", "fwd", fwd_o, 1'b0);
        chk("R11", "smi", smi_o, 1'b0);
        @(posedge clk);
        #1;
        chk("R11", "pend", pend_o, (mst != 0));
        cyc_vld = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cyc_vld = 1'b0;
        @(posedge clk);
        #1;
        rst = 1'b0;
        mst = 0;
        chk("R1", "pend", pend_o, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cyc_vld = 1'b0; cyc_addr = '0; cyc_wr = 1'b0;
        cyc_wdata = '0; cfg = '0;
        for (int ci = 0; ci < 32; ci++) begin
            logic [4:0] cb;
            cb = 5'(ci);
            // bits 4..6 take varying values that must not matter (R11)
            cfg = {cb[4], 3'(ci * 5), cb[3:0]};
            do_reset();
            for (int a = 0; a < 6; a++) begin
                for (int b = 0; b < 6; b++) begin
                    for (int c = 0; c < 6; c++) begin
                        do_cycle(a);
                        if (c == 0) quiet_cycle(1'b0);
                        do_cycle(b);
                        if (c == 1) quiet_cycle(1'b1);
                        do_cycle(c);
                    end
                end
            end
            // reset in the middle of an open sequence
            do_cycle(0);
            do_cycle(4);
            do_reset();
            do_cycle(3);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule